// File: doc/BRIEF.md
# Periodic Refresh and Bus Stall Generator

This block sits beside the bus cycle logic of a memory-mapped CPU system and runs on the expansion clock. It adds two periodic disturbances to bus traffic. The first is a one-clock refresh pulse that repeats at a fixed period. The pulse always drives the long cartridge strobe. It also drives the cartridge chip enable, but only while software has turned the DRAM mode on through a control register.

The second disturbance is an acknowledge stall that repeats at a second, independent period. When a stall falls due during an access, the acknowledge returned to the CPU is held inactive for two or three CPU clocks. Every strobe that waits on that acknowledge is stretched by the same amount. A stall that falls due between accesses is held until the address strobe next asserts. No bus request is raised for either disturbance.

Address decoding, the strobes themselves and the CPU are outside this block. It receives the address strobe and the base acknowledge, and it returns the stretched acknowledge and the two extra-pulse strobes. All strobes are active low.

Top module: `refresh_stall_gen`

## Requirements
- R1: After reset is released, `long_n` goes low for exactly one clock when `REF_PERIOD-1` (199) clock edges have passed. It then goes low for one clock every `REF_PERIOD` (200) clocks.
- R2: While DRAM mode is on, `ce_n` goes low in exactly the same clock as each `long_n` refresh pulse.
- R3: While DRAM mode is off, `ce_n` stays high, and `long_n` keeps pulsing.
- R4: A register write with `reg_addr` equal to `REG_ADDR` (0xA11200) sets the DRAM mode when `reg_wdata` equals 0x0100 and clears it for any other value. Writes to other addresses leave the mode unchanged. Reset clears the mode.
- R5: A stall falls due every `STALL_PERIOD` (222) clocks, first in the clock where 221 edges have passed since reset. While the address strobe is held low, successive stalls start exactly 222 clocks apart.
- R6: While a stall lasts, `ack_n` is high whatever `ack_base_n` is. Stall lengths alternate between 2 and 3 CPU clocks, that is 2×`CPU_DIV` and 3×`CPU_DIV` expansion clocks (4 then 6 by default), and the first stall after reset is the short one.
- R7: A stall that falls due while `as_n` is high is held pending. It starts in the same clock in which `as_n` next goes low, and it does not touch `ack_n` while `as_n` stays high.
- R8: Outside a stall, `ack_n` equals `ack_base_n`.
- R9: During reset and right after it, `long_n` and `ce_n` are high and no stall is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Expansion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one clock per write |
| reg_addr | input | 24 | Register write address |
| reg_wdata | input | 16 | Register write data |
| as_n | input | 1 | Address strobe from the CPU, active low |
| ack_base_n | input | 1 | Acknowledge from the decoder before stretching, active low |
| ack_n | output | 1 | Acknowledge to the CPU, held high during a stall |
| ce_n | output | 1 | Extra refresh pulse on the cartridge chip enable, DRAM mode only |
| long_n | output | 1 | Extra refresh pulse on the long cartridge strobe |

## Verification
The assertions assume that `as_n` and `ack_base_n` are synchronous to `clk` and settle between edges. They also assume that `REG_ADDR` is written at most once per clock. The bench changes every input just after a falling edge and samples one time unit later, so the combinational path from `as_n` to `ack_n` is observed in the same cycle as the strobe. Each scenario starts from a fresh reset, so the expected pulse and stall instants follow directly from the two periods.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  // Next value of a free-running modulo counter.
  function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned period);
    return (cur >= period - 1) ? 0 : cur + 1;
  endfunction

  // Stall length in expansion clocks: short = 2 CPU clocks, long = 3 CPU clocks.
  function automatic int unsigned stall_cycles(input logic long_sel, input int unsigned div);
    return (long_sel ? 3 : 2) * div;
  endfunction

endpackage

// File: rtl/rsg_period_tick.sv
module rsg_period_tick #(
  parameter int unsigned PERIOD = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  import rsg_pkg::*;

  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CW'(wrap_next(32'(cnt_q), PERIOD));
  end

  assign tick = (cnt_q == CW'(PERIOD - 1));

endmodule

// File: rtl/rsg_ctrl_reg.sv
module rsg_ctrl_reg #(
  parameter int unsigned    AW       = 24,
  parameter int unsigned    DW       = 16,
  parameter logic [AW-1:0]  REG_ADDR = 24'hA11200,
  parameter logic [DW-1:0]  EN_VALUE = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          dram_en
);
  logic hit;
  assign hit = we && (addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dram_en <= 1'b0;
    else if (hit) dram_en <= (wdata == EN_VALUE);
  end

endmodule

// File: rtl/rsg_stall_seq.sv
module rsg_stall_seq #(
  parameter int unsigned CPU_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic due,
  input  logic as_n,
  output logic start,
  output logic busy,
  output logic pending,
  output logic len_sel
);
  import rsg_pkg::*;

  localparam int unsigned MAXLEN = 3 * CPU_DIV;
  localparam int unsigned SCW    = $clog2(MAXLEN + 1);

  logic [SCW-1:0] cnt_q;
  logic           armed;

  assign armed = pending | due;
  assign busy  = (cnt_q != '0);
  assign start = armed && !as_n && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
      len_sel <= 1'b0;
    end else begin
      pending <= armed && !start;
      if (start) begin
        cnt_q   <= SCW'(stall_cycles(len_sel, CPU_DIV) - 1);
        len_sel <= !len_sel;
      end else if (busy) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/refresh_stall_gen.sv
module refresh_stall_gen #(
  parameter int unsigned   REF_PERIOD   = 200,
  parameter int unsigned   STALL_PERIOD = 222,
  parameter int unsigned   CPU_DIV      = 2,
  parameter int unsigned   AW           = 24,
  parameter int unsigned   DW           = 16,
  parameter logic [23:0]   REG_ADDR     = 24'hA11200,
  parameter logic [15:0]   EN_VALUE     = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          as_n,
  input  logic          ack_base_n,
  output logic          ack_n,
  output logic          ce_n,
  output logic          long_n
);
  // Named internal events, also observed by the bound checker.
  logic ref_tick;
  logic stall_tick;
  logic dram_en;
  logic stall_start;
  logic stall_busy;
  logic stall_pending;
  logic stall_len_sel;

  rsg_period_tick #(.PERIOD(REF_PERIOD)) u_ref_tick (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick)
  );

  rsg_period_tick #(.PERIOD(STALL_PERIOD)) u_stall_tick (
    .clk(clk), .rst_n(rst_n), .tick(stall_tick)
  );

  rsg_ctrl_reg #(
    .AW(AW), .DW(DW),
    .REG_ADDR(AW'(REG_ADDR)), .EN_VALUE(DW'(EN_VALUE))
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .dram_en(dram_en)
  );

  rsg_stall_seq #(.CPU_DIV(CPU_DIV)) u_stall (
    .clk(clk), .rst_n(rst_n), .due(stall_tick), .as_n(as_n),
    .start(stall_start), .busy(stall_busy), .pending(stall_pending),
    .len_sel(stall_len_sel)
  );

  assign long_n = !ref_tick;
  assign ce_n   = !(ref_tick && dram_en);
  assign ack_n  = ack_base_n || stall_busy || stall_start;

endmodule

// File: rtl/refresh_stall_chk.sv
module refresh_stall_chk (
  input logic clk,
  input logic rst_n,
  input logic as_n,
  input logic ack_base_n,
  input logic ack_n,
  input logic ce_n,
  input logic long_n,
  input logic dram_en,
  input logic stall_start,
  input logic stall_busy,
  input logic stall_pending,
  input logic stall_len_sel
);

  // R1: refresh pulse lasts one clock
  p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !long_n |=> long_n);

  // R2: chip enable pulse only coincides with the long strobe pulse
  p_ce_with_long_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> !long_n);

  // R3: chip enable pulse needs DRAM mode
  p_ce_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> dram_en);

  // R6: acknowledge held during stall
  p_ack_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_busy |-> ack_n);

  // R6: stall length selection alternates on each stall
  p_len_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_start |=> (stall_len_sel != $past(stall_len_sel)));

  // R7: a stall only starts with the address strobe low
  p_start_needs_as_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_start |-> !as_n);

  // R7: starting consumes the pending stall
  p_pending_consumed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_start |=> !stall_pending);

  // R8: pass-through outside a stall
  p_ack_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_busy && !stall_start) |-> (ack_n == ack_base_n));

endmodule

bind refresh_stall_gen refresh_stall_chk u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .ack_base_n(ack_base_n),
  .ack_n(ack_n), .ce_n(ce_n), .long_n(long_n), .dram_en(dram_en),
  .stall_start(stall_start), .stall_busy(stall_busy),
  .stall_pending(stall_pending), .stall_len_sel(stall_len_sel)
);

// File: tb/refresh_stall_gen_tb.sv
`timescale 1ns/1ps
module refresh_stall_gen_tb;

  localparam int REF_P   = 200;
  localparam int STALL_P = 222;
  localparam int DIV     = 2;
  localparam int SHORT_L = 2 * DIV;
  localparam int LONG_L  = 3 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [23:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        as_n = 1'b1;
  logic        ack_base_n = 1'b1;
  logic        ack_n, ce_n, long_n;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  refresh_stall_gen #(.REF_PERIOD(REF_P), .STALL_PERIOD(STALL_P), .CPU_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .as_n(as_n), .ack_base_n(ack_base_n),
    .ack_n(ack_n), .ce_n(ce_n), .long_n(long_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reset, then release at a falling edge; caller's input values are kept.
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_reg(input logic [23:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // Waits for the next refresh pulse; returns ce_n sampled in that clock.
  task automatic wait_pulse(output logic ce_seen);
    ce_seen = 1'b1;
    for (int i = 0; i < 2 * REF_P; i++) begin
      @(negedge clk); #1;
      if (!long_n) begin ce_seen = ce_n; return; end
    end
    check(1'b0, "R1 pulse missing", 0, 1);
  endtask

  task automatic t_reset();
    as_n = 1'b1; ack_base_n = 1'b1;
    @(negedge clk); rst_n = 1'b0; #1;
    check(long_n == 1'b1, "R9 long_n in reset", long_n, 1);
    check(ce_n == 1'b1,   "R9 ce_n in reset", ce_n, 1);
    check(ack_n == 1'b1,  "R9 ack_n in reset", ack_n, 1);
    @(negedge clk); rst_n = 1'b1;
    ack_base_n = 1'b0; #1;
    check(ack_n == 1'b0, "R8 ack passes after reset", ack_n, 0);
    ack_base_n = 1'b1;
  endtask

  task automatic t_refresh();
    int first = -1, second = -1, ce_low = 0;
    as_n = 1'b1; ack_base_n = 1'b1;
    do_reset();
    for (int i = 1; i <= 2 * REF_P + 5; i++) begin
      @(negedge clk); #1;
      if (!ce_n) ce_low++;
      if (!long_n) begin
        if (first < 0) first = i; else if (second < 0) second = i;
      end
    end
    check(first == REF_P - 1, "R1 first pulse cycle", first, REF_P - 1);
    check(second - first == REF_P, "R1 pulse spacing", second - first, REF_P);
    check(ce_low == 0, "R3 ce_n quiet with mode off", ce_low, 0);
  endtask

  task automatic t_dram();
    logic c;
    as_n = 1'b1; ack_base_n = 1'b1;
    do_reset();
    wr_reg(24'hA11200, 16'h0100);
    wait_pulse(c);
    check(c == 1'b0, "R2 ce_n with long_n when enabled", c, 0);
    wr_reg(24'hA11202, 16'h0000);
    wait_pulse(c);
    check(c == 1'b0, "R4 other address ignored", c, 0);
    wr_reg(24'hA11200, 16'h0101);
    wait_pulse(c);
    check(c == 1'b1, "R4 other value disables", c, 1);
    wr_reg(24'hA11200, 16'h0100);
    do_reset();
    wait_pulse(c);
    check(c == 1'b1, "R4 reset clears mode", c, 1);
  endtask

  task automatic t_stall_cont();
    int st[3];
    int ln[3];
    int n = 0, run = 0;
    as_n = 1'b0; ack_base_n = 1'b0;
    do_reset();
    for (int i = 1; i <= 3 * STALL_P + 20; i++) begin
      @(negedge clk); #1;
      if (ack_n) begin
        if (run == 0 && n < 3) st[n] = i;
        run++;
      end else if (run > 0) begin
        if (n < 3) ln[n] = run;
        n++; run = 0;
      end
    end
    check(n == 3, "R5 stall count", n, 3);
    check(st[0] == STALL_P - 1, "R5 first stall cycle", st[0], STALL_P - 1);
    check(st[1] - st[0] == STALL_P, "R5 stall spacing", st[1] - st[0], STALL_P);
    check(ln[0] == SHORT_L, "R6 first stall short", ln[0], SHORT_L);
    check(ln[1] == LONG_L,  "R6 second stall long", ln[1], LONG_L);
    check(ln[2] == SHORT_L, "R6 third stall short", ln[2], SHORT_L);
    as_n = 1'b1; ack_base_n = 1'b1;
  endtask

  task automatic t_pending();
    int bad = 0, run;
    as_n = 1'b1; ack_base_n = 1'b0;
    do_reset();
    for (int i = 1; i <= STALL_P + 60; i++) begin
      @(negedge clk); #1;
      if (ack_n) bad++;
    end
    check(bad == 0, "R7 no stall while idle", bad, 0);
    @(negedge clk);
    as_n = 1'b0; #1;
    check(ack_n == 1'b1, "R7 stall starts with strobe", ack_n, 1);
    run = ack_n ? 1 : 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      if (ack_n) run++; else break;
    end
    check(run == SHORT_L, "R7 pending stall length", run, SHORT_L);
    check(ack_n == 1'b0, "R8 ack returns after stall", ack_n, 0);
    ack_base_n = 1'b1; #1;
    check(ack_n == 1'b1, "R8 ack follows base high", ack_n, 1);
    as_n = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_refresh();
    t_dram();
    t_stall_cont();
    t_pending();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule